// File: doc/BRIEF.md
# Two-wire slave framing front end

This block is the bus-facing half of a small register device on a two-wire serial bus. It samples the clock and data lines with the system clock and recognises start and stop conditions. After a start it takes in one address byte. The upper nibble of that byte must equal a fixed device-type code and the lower nibble must equal four strap inputs. The address byte has no read/write bit, because the command byte that follows decides the direction. The block acknowledges by pulling the data line low through an open-drain enable.

After the command byte the block sorts the command into one of four kinds:
- a register read, where the block sends a byte from `rdata_i` MSB first;
- a register write, where one data byte is accepted and acknowledged;
- a step command, where every later bit is passed on as a raw up or down event;
- a plain two-byte command, where nothing further is accepted.

Each byte is handed to the downstream executor through a one-cycle strobe. So is each step event and each stop condition.

While the executor reports a nonvolatile write in progress, a matching address is not acknowledged. A master can therefore poll with start plus address until it sees an acknowledge.

Top module: `tw_slave_front`

## Requirements
- R1: After reset `sda_pull_o` is 0 (line released) and no strobe output is high.
- R2: After a start, an address byte whose bits 7:4 are 0101 and whose bits 3:0 equal `strap_i` is acknowledged: the data line is low during the ninth clock high.
- R3: An address byte with a wrong type nibble or a wrong strap nibble gets no acknowledge. Every later byte up to the next start gets no acknowledge and raises no strobe.
- R4: While `nv_busy_i` is 1 when the address byte completes, a matching address gets no acknowledge. Once `nv_busy_i` is 0, the same sequence is acknowledged.
- R5: The byte after an accepted address is the command. It appears on `cmd_o` with a one-cycle `cmd_valid_o` pulse and is acknowledged.
- R6: A command whose bits 7:4 are 1010 or 1100 takes one data byte. That byte appears on `wdata_o` with a one-cycle `wdata_valid_o` pulse and is acknowledged. A further byte is neither acknowledged nor strobed.
- R7: A command whose bits 7:4 are 1001 or 1011 is a read. `rdata_i` is sampled at the SCL falling edge that ends the command acknowledge and is sent MSB first. The line is released for the master's acknowledge bit and stays released afterwards. `sda_pull_o` changes only while SCL is low.
- R8: A command whose bits 7:4 are 0010 is a step command. Each later bit gives one `step_valid_o` pulse at the SCL falling edge that ends that bit. `step_up_o` equals the data level seen at the SCL rise (1 = up). A clock high that ends in a stop gives no event.
- R9: Any other command is acknowledged and then ends the frame: a following byte is not acknowledged and gives no `wdata_valid_o`. At most one strobe output is high in any cycle.
- R10: A stop gives a one-cycle `stop_seen_o` pulse and returns the block to idle. A start in any state, including the middle of a byte, restarts address reception.
- R11: Before the first start, bus traffic is ignored: no acknowledge and no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired) |
| sda_pull_o | output | 1 | 1 = pull data line low, 0 = release |
| strap_i | input | 4 | Strap address nibble to match |
| nv_busy_i | input | 1 | Executor nonvolatile write in progress |
| rdata_i | input | 8 | Register value to return for reads |
| cmd_valid_o | output | 1 | One-cycle strobe: command byte received |
| cmd_o | output | 8 | Last command byte |
| wdata_valid_o | output | 1 | One-cycle strobe: data byte received |
| wdata_o | output | 8 | Last data byte |
| step_valid_o | output | 1 | One-cycle strobe: one step bit received |
| step_up_o | output | 1 | Direction of the step: 1 up, 0 down |
| stop_seen_o | output | 1 | One-cycle strobe: stop condition |

## Verification
Two functions can meet in a single SCL high period: recording a step bit at the SCL rise, and detecting a stop on the SDA rise that follows. The bench ends a step stream with a stop whose SCL rise has SDA low. It then counts the step pulses and the recorded directions, so a stray down step would show. The second meeting point is a start that arrives in the middle of a command byte while the bit counter is part way through. The bench judges it by the next full address and command being accepted with the right `cmd_o`.

// File: rtl/tw_pkg.sv
package tw_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W);
  localparam int CODE_W = 4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_CMD, ST_WDATA, ST_ACK, ST_RDATA, ST_MACK, ST_STEP
  } fr_state_e;

  typedef enum logic [1:0] {
    CK_PLAIN, CK_READ, CK_WRITE, CK_STEP
  } cmd_kind_e;

  function automatic cmd_kind_e cmd_kind(input logic [BYTE_W-1:0] c);
    case (c[BYTE_W-1 -: CODE_W])
      4'b1001, 4'b1011: return CK_READ;
      4'b1010, 4'b1100: return CK_WRITE;
      4'b0010:          return CK_STEP;
      default:          return CK_PLAIN;
    endcase
  endfunction

  function automatic logic addr_match(input logic [BYTE_W-1:0] b,
                                      input logic [CODE_W-1:0] type_code,
                                      input logic [CODE_W-1:0] strap);
    return (b[BYTE_W-1 -: CODE_W] == type_code) && (b[CODE_W-1:0] == strap);
  endfunction

  function automatic logic is_start(input logic scl_now, input logic scl_old,
                                    input logic sda_now, input logic sda_old);
    return scl_now & scl_old & sda_old & ~sda_now;
  endfunction

  function automatic logic is_stop(input logic scl_now, input logic scl_old,
                                   input logic sda_now, input logic sda_old);
    return scl_now & scl_old & ~sda_old & sda_now;
  endfunction
endpackage

// File: rtl/tw_line_sync.sv
module tw_line_sync
  import tw_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic              scl_prev, sda_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_prev <= scl_pipe[STAGES-1];
      sda_prev <= sda_pipe[STAGES-1];
    end
  end

  assign scl_lvl   = scl_pipe[STAGES-1];
  assign sda_lvl   = sda_pipe[STAGES-1];
  assign scl_rise  = scl_lvl & ~scl_prev;
  assign scl_fall  = ~scl_lvl & scl_prev;
  assign start_evt = is_start(scl_lvl, scl_prev, sda_lvl, sda_prev);
  assign stop_evt  = is_stop(scl_lvl, scl_prev, sda_lvl, sda_prev);
endmodule

// File: rtl/tw_frame_fsm.sv
module tw_frame_fsm
  import tw_pkg::*;
#(
  parameter logic [CODE_W-1:0] TYPE_CODE = 4'b0101
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic [CODE_W-1:0] strap_i,
  input  logic              nv_busy_i,
  input  logic [BYTE_W-1:0] rdata_i,
  output logic              sda_pull_o,
  output logic              cmd_valid_o,
  output logic [BYTE_W-1:0] cmd_o,
  output logic              wdata_valid_o,
  output logic [BYTE_W-1:0] wdata_o,
  output logic              step_valid_o,
  output logic              step_up_o,
  output logic              stop_seen_o,
  output logic              idle_o
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  fr_state_e         state, after_ack;
  logic [CNT_W-1:0]  bitcnt;
  logic [BYTE_W-1:0] rx_sh, tx_sh;
  logic              ninth, step_pend, step_lvl;
  logic [BYTE_W-1:0] rx_byte;
  logic              byte_done;

  function automatic fr_state_e kind_next(input cmd_kind_e k);
    case (k)
      CK_READ:  return ST_RDATA;
      CK_WRITE: return ST_WDATA;
      CK_STEP:  return ST_STEP;
      default:  return ST_IDLE;
    endcase
  endfunction

  assign rx_byte   = {rx_sh[BYTE_W-2:0], sda_lvl};
  assign byte_done = scl_rise && (bitcnt == LAST_BIT);
  assign idle_o    = (state == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state         <= ST_IDLE;
      after_ack     <= ST_IDLE;
      bitcnt        <= '0;
      rx_sh         <= '0;
      tx_sh         <= '0;
      ninth         <= 1'b0;
      step_pend     <= 1'b0;
      step_lvl      <= 1'b0;
      sda_pull_o    <= 1'b0;
      cmd_valid_o   <= 1'b0;
      cmd_o         <= '0;
      wdata_valid_o <= 1'b0;
      wdata_o       <= '0;
      step_valid_o  <= 1'b0;
      step_up_o     <= 1'b0;
      stop_seen_o   <= 1'b0;
    end else begin
      cmd_valid_o   <= 1'b0;
      wdata_valid_o <= 1'b0;
      step_valid_o  <= 1'b0;
      stop_seen_o   <= 1'b0;
      if (start_evt) begin
        state      <= ST_ADDR;
        bitcnt     <= '0;
        ninth      <= 1'b0;
        step_pend  <= 1'b0;
        sda_pull_o <= 1'b0;
      end else if (stop_evt) begin
        state       <= ST_IDLE;
        ninth       <= 1'b0;
        step_pend   <= 1'b0;
        sda_pull_o  <= 1'b0;
        stop_seen_o <= 1'b1;
      end else begin
        case (state)
          ST_ADDR, ST_CMD, ST_WDATA: begin
            if (scl_rise) begin
              rx_sh  <= rx_byte;
              bitcnt <= bitcnt + CNT_W'(1);
            end
            if (byte_done) begin
              case (state)
                ST_ADDR: begin
                  if (addr_match(rx_byte, TYPE_CODE, strap_i) && !nv_busy_i) begin
                    state     <= ST_ACK;
                    after_ack <= ST_CMD;
                  end else begin
                    state <= ST_IDLE;
                  end
                end
                ST_CMD: begin
                  cmd_o       <= rx_byte;
                  cmd_valid_o <= 1'b1;
                  state       <= ST_ACK;
                  after_ack   <= kind_next(cmd_kind(rx_byte));
                end
                default: begin
                  wdata_o       <= rx_byte;
                  wdata_valid_o <= 1'b1;
                  state         <= ST_ACK;
                  after_ack     <= ST_IDLE;
                end
              endcase
            end
          end
          ST_ACK: begin
            if (scl_rise) ninth <= 1'b1;
            if (scl_fall) begin
              if (!ninth) begin
                sda_pull_o <= 1'b1;
              end else begin
                ninth  <= 1'b0;
                bitcnt <= '0;
                state  <= after_ack;
                if (after_ack == ST_RDATA) begin
                  tx_sh      <= rdata_i;
                  sda_pull_o <= ~rdata_i[BYTE_W-1];
                end else begin
                  sda_pull_o <= 1'b0;
                end
              end
            end
          end
          ST_RDATA: begin
            if (scl_rise) begin
              bitcnt <= bitcnt + CNT_W'(1);
              if (bitcnt == LAST_BIT) state <= ST_MACK;
            end
            if (scl_fall) begin
              tx_sh      <= {tx_sh[BYTE_W-2:0], 1'b0};
              sda_pull_o <= ~tx_sh[BYTE_W-2];
            end
          end
          ST_MACK: begin
            if (scl_rise) ninth <= 1'b1;
            if (scl_fall) begin
              sda_pull_o <= 1'b0;
              if (ninth) begin
                ninth <= 1'b0;
                state <= ST_IDLE;
              end
            end
          end
          ST_STEP: begin
            if (scl_rise) begin
              step_pend <= 1'b1;
              step_lvl  <= sda_lvl;
            end
            if (scl_fall && step_pend) begin
              step_valid_o <= 1'b1;
              step_up_o    <= step_lvl;
              step_pend    <= 1'b0;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/tw_slave_front.sv
module tw_slave_front
  import tw_pkg::*;
#(
  parameter int                SYNC_STAGES = 2,
  parameter logic [CODE_W-1:0] TYPE_CODE   = 4'b0101
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_pull_o,
  input  logic [CODE_W-1:0] strap_i,
  input  logic              nv_busy_i,
  input  logic [BYTE_W-1:0] rdata_i,
  output logic              cmd_valid_o,
  output logic [BYTE_W-1:0] cmd_o,
  output logic              wdata_valid_o,
  output logic [BYTE_W-1:0] wdata_o,
  output logic              step_valid_o,
  output logic              step_up_o,
  output logic              stop_seen_o
);
  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_evt, stop_evt;
  logic fr_idle;

  tw_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_lvl   (scl_lvl),
    .sda_lvl   (sda_lvl),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt)
  );

  tw_frame_fsm #(.TYPE_CODE(TYPE_CODE)) fsm_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .sda_lvl       (sda_lvl),
    .scl_rise      (scl_rise),
    .scl_fall      (scl_fall),
    .start_evt     (start_evt),
    .stop_evt      (stop_evt),
    .strap_i       (strap_i),
    .nv_busy_i     (nv_busy_i),
    .rdata_i       (rdata_i),
    .sda_pull_o    (sda_pull_o),
    .cmd_valid_o   (cmd_valid_o),
    .cmd_o         (cmd_o),
    .wdata_valid_o (wdata_valid_o),
    .wdata_o       (wdata_o),
    .step_valid_o  (step_valid_o),
    .step_up_o     (step_up_o),
    .stop_seen_o   (stop_seen_o),
    .idle_o        (fr_idle)
  );
endmodule

// File: rtl/tw_slave_front_chk.sv
module tw_slave_front_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_lvl,
  input logic scl_fall,
  input logic stop_evt,
  input logic fr_idle,
  input logic sda_pull_o,
  input logic cmd_valid_o,
  input logic wdata_valid_o,
  input logic step_valid_o,
  input logic stop_seen_o
);
  // R7: the data line driver moves only while the clock line is low
  a_r7_pull_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull_o) |-> !scl_lvl);

  // R5: the command strobe lasts one cycle
  a_r5_cmd_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |=> !cmd_valid_o);

  // R10: a detected stop is reported in the next cycle
  a_r10_stop_reported: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> stop_seen_o);

  // R10: the stop strobe lasts one cycle
  a_r10_stop_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    stop_seen_o |=> !stop_seen_o);

  // R8: a step event follows a clock falling edge
  a_r8_step_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    step_valid_o |-> $past(scl_fall));

  // R9: strobes never overlap
  a_r9_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_valid_o, wdata_valid_o, step_valid_o, stop_seen_o}));

  // R3: while idle the data line is released
  a_r3_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    fr_idle |-> !sda_pull_o);
endmodule

bind tw_slave_front tw_slave_front_chk chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .scl_lvl       (scl_lvl),
  .scl_fall      (scl_fall),
  .stop_evt      (stop_evt),
  .fr_idle       (fr_idle),
  .sda_pull_o    (sda_pull_o),
  .cmd_valid_o   (cmd_valid_o),
  .wdata_valid_o (wdata_valid_o),
  .step_valid_o  (step_valid_o),
  .stop_seen_o   (stop_seen_o)
);

// File: tb/tw_slave_front_tb.sv
`timescale 1ns/1ps
module tw_slave_front_tb_top;
  localparam time Q = 100ns;
  localparam logic [3:0] STRAP = 4'b1010;
  localparam logic [7:0] MY_ADDR = {4'b0101, STRAP};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1;
  logic       sda_m = 1'b1;
  logic       nv_busy = 1'b0;
  logic [7:0] rdata = 8'h00;
  logic       sda_pull, cmd_valid, wdata_valid, step_valid, step_up, stop_seen;
  logic [7:0] cmd, wdata;
  logic       sda_line;

  int checks = 0;
  int errors = 0;
  int n_cmd = 0, n_wd = 0, n_step = 0, n_stop = 0, n_strobe_early = 0;
  logic [7:0] last_cmd = 8'h00, last_wd = 8'h00;
  logic [7:0] step_hist = 8'h00;
  bit done = 0;

  always #5ns clk = ~clk;
  assign sda_line = sda_m & ~sda_pull;

  tw_slave_front dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_pull_o(sda_pull), .strap_i(STRAP), .nv_busy_i(nv_busy),
    .rdata_i(rdata), .cmd_valid_o(cmd_valid), .cmd_o(cmd),
    .wdata_valid_o(wdata_valid), .wdata_o(wdata),
    .step_valid_o(step_valid), .step_up_o(step_up), .stop_seen_o(stop_seen)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (cmd_valid) begin n_cmd++; last_cmd = cmd; end
      if (wdata_valid) begin n_wd++; last_wd = wdata; end
      if (step_valid) begin n_step++; step_hist = {step_hist[6:0], step_up}; end
      if (stop_seen) n_stop++;
    end else if (sda_pull | cmd_valid | wdata_valid | step_valid | stop_seen) begin
      n_strobe_early++;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic write_bit(input logic b);
    sda_m = b; #Q; scl = 1'b1; #(2*Q); scl = 1'b0; #Q;
  endtask

  task automatic read_bit(output logic v);
    sda_m = 1'b1; #Q; scl = 1'b1; #Q; v = sda_line; #Q; scl = 1'b0; #Q;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; #Q; scl = 1'b1; #Q; sda_m = 1'b0; #Q; scl = 1'b0; #Q;
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; #Q; scl = 1'b1; #Q; sda_m = 1'b1; #(2*Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    logic v;
    for (int i = 7; i >= 0; i--) write_bit(b[i]);
    read_bit(v);
    acked = ~v;
  endtask

  task automatic recv_byte(output logic [7:0] b, input logic [7:0] swap);
    logic v;
    for (int i = 7; i >= 0; i--) begin
      read_bit(v);
      b[i] = v;
      if (i == 7) rdata = swap;
    end
    write_bit(1'b0);
  endtask

  task automatic t_reset();
    chk("R1 pull at reset", sda_pull, 0);
    chk("R1 no strobe during reset", n_strobe_early, 0);
    chk("R1 cmd count", n_cmd, 0);
  endtask

  task automatic t_no_start();
    logic ack;
    scl = 1'b0; #Q;
    send_byte(MY_ADDR, ack);
    chk("R11 address without start not acked", ack, 0);
    send_byte(8'hA0, ack);
    chk("R11 no cmd strobe without start", n_cmd, 0);
    chk("R11 line released", sda_pull, 0);
  endtask

  task automatic t_addr();
    logic ack;
    int c0;
    bus_start(); send_byte(MY_ADDR, ack);
    chk("R2 matching address acked", ack, 1);
    bus_stop();
    c0 = n_cmd;
    bus_start(); send_byte({4'b0110, STRAP}, ack);
    chk("R3 wrong type not acked", ack, 0);
    send_byte(8'hA0, ack);
    chk("R3 byte after mismatch not acked", ack, 0);
    chk("R3 no cmd strobe after mismatch", n_cmd, c0);
    bus_stop();
    bus_start(); send_byte({4'b0101, STRAP ^ 4'b0001}, ack);
    chk("R3 wrong strap not acked", ack, 0);
    bus_stop();
  endtask

  task automatic t_busy();
    logic ack;
    nv_busy = 1'b1;
    bus_start(); send_byte(MY_ADDR, ack);
    chk("R4 busy address not acked", ack, 0);
    bus_stop();
    nv_busy = 1'b0;
    bus_start(); send_byte(MY_ADDR, ack);
    chk("R4 address acked after busy", ack, 1);
    bus_stop();
  endtask

  task automatic t_write(input logic [7:0] c, input logic [7:0] d);
    logic ack;
    int c0, w0, s0;
    c0 = n_cmd; w0 = n_wd; s0 = n_stop;
    bus_start(); send_byte(MY_ADDR, ack);
    send_byte(c, ack);
    chk("R5 command acked", ack, 1);
    chk("R5 one cmd strobe", n_cmd - c0, 1);
    chk("R5 cmd value", last_cmd, c);
    send_byte(d, ack);
    chk("R6 data acked", ack, 1);
    chk("R6 data value", last_wd, d);
    send_byte(8'h55, ack);
    chk("R6 extra byte not acked", ack, 0);
    chk("R6 one data strobe", n_wd - w0, 1);
    bus_stop();
    chk("R10 one stop strobe", n_stop - s0, 1);
  endtask

  task automatic t_read(input logic [7:0] c, input logic [7:0] v);
    logic ack;
    logic [7:0] got;
    rdata = v;
    bus_start(); send_byte(MY_ADDR, ack);
    send_byte(c, ack);
    chk("R7 read command acked", ack, 1);
    recv_byte(got, ~v);
    chk("R7 read byte MSB first", got, v);
    chk("R7 line released after master ack", sda_pull, 0);
    bus_stop();
  endtask

  task automatic t_step();
    logic ack;
    int n0;
    n0 = n_step;
    bus_start(); send_byte(MY_ADDR, ack);
    send_byte(8'h21, ack);
    chk("R8 step command acked", ack, 1);
    write_bit(1'b1); write_bit(1'b1); write_bit(1'b0); write_bit(1'b1);
    bus_stop();
    chk("R8 four step events, none from stop", n_step - n0, 4);
    chk("R8 step directions up,up,down,up", step_hist[3:0], 4'b1101);
  endtask

  task automatic t_plain();
    logic ack;
    int w0;
    w0 = n_wd;
    bus_start(); send_byte(MY_ADDR, ack);
    send_byte(8'hD2, ack);
    chk("R9 plain command acked", ack, 1);
    send_byte(8'h77, ack);
    chk("R9 byte after plain command not acked", ack, 0);
    chk("R9 no data strobe", n_wd, w0);
    bus_stop();
  endtask

  task automatic t_restart();
    logic ack;
    int c0;
    bus_start(); send_byte(MY_ADDR, ack);
    write_bit(1'b1); write_bit(1'b0); write_bit(1'b1);
    c0 = n_cmd;
    bus_start(); send_byte(MY_ADDR, ack);
    chk("R10 address acked after repeated start", ack, 1);
    send_byte(8'hA0, ack);
    chk("R10 cmd after repeated start", last_cmd, 8'hA0);
    chk("R10 one cmd strobe after restart", n_cmd - c0, 1);
    bus_stop();
  endtask

  initial begin
    #1000ns;
    t_reset();
    rst_n = 1'b1;
    #200ns;
    t_no_start();
    t_addr();
    t_busy();
    t_write(8'hA2, 8'h3C);
    t_write(8'hC7, 8'hA5);
    t_read(8'h93, 8'hB6);
    t_read(8'hB1, 8'h01);
    t_step();
    t_plain();
    t_restart();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1500us;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule